// File: doc/BRIEF.md
# Token-Counting Coherence Line Controller

This block keeps the coherence state of one first-level cache line under a protocol in which permission is measured in tokens. A fixed number of tokens, `TOKENS`, exists for the line across the whole system. The controller holds some share of them, together with an owner flag and a dirty flag. A load may proceed while at least one token is held. A store needs every token. The visible state (I, S, O, M, M_W, MM, MM_W) is derived each cycle from the token count, the owner and dirty flags, and a lock-in window.

Local requests arrive on a one-cycle CPU port and are answered in the same cycle with hit, miss or stall. Tokens arrive on a grant port and leave on a token-out port, either because of a replacement or because of an external request. A miss opens a pending request. If that request sees no grant for `RETRY_LIMIT` cycles, it is escalated to a persistent request. When a pending miss collects all tokens, the line enters a timed window for `WIN_CYCLES` cycles. During that window eviction and ordinary external requests are held off. An external persistent request overrides everything so that a starving requester gets the tokens.

Top module: `tok_line_ctrl`

## Requirements
- R1: The token count changes only by grants added and token-out counts removed in the same cycle, and it never exceeds `TOKENS`.
- R2: Encodings: cpu_op 0 is load, 1 is store and 2 is replace. line_state codes are I=0, S=1, O=2, M=3, M_W=4, MM=5 and MM_W=6. A load hits when at least one token is held and misses otherwise. A store hits only in M_W, MM or MM_W, which means all tokens are held. At most one of hit, miss and stall is high.
- R3: A store in I, S, O or M is a miss. In M, where all tokens are already held, no request is issued. The line enters M_W one cycle after the pending store, and the store then hits.
- R4: A store that hits in M_W moves the line to MM_W in the next cycle without issuing a request.
- R5: While the window is open (M_W or MM_W), a replacement gets cpu_stall and a non-persistent external request gets ext_stall.
- R6: A pending miss that gathers all tokens opens the window. It lasts `WIN_CYCLES` cycles, after which MM_W falls back to MM and M_W to M.
- R7: An accepted non-persistent external request sends all held tokens, with the owner flag, and the line becomes I. The exception is a read in O or S with more than one token: the line keeps one token and becomes S. A non-persistent external request is stalled whenever cpu_valid is high.
- R8: A persistent external request is never stalled. It takes all tokens, even inside the window, and closes the window. Any CPU request in that cycle is stalled.
- R9: A load miss with no pending request, or a store miss with no pending store, pulses req_valid when tokens must come from elsewhere. While the request is pending, further misses issue nothing.
- R10: A pending request that sees no grant for `RETRY_LIMIT` consecutive cycles issues one req_valid pulse with req_persist high.
- R11: A replacement outside the window hits, sends all held tokens out and leaves the line in I.
- R12: After reset the line is I with zero tokens, and tok_out_valid and req_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Local request present this cycle |
| cpu_op | input | 2 | 0 load, 1 store, 2 replace |
| cpu_hit | output | 1 | Local request completes |
| cpu_miss | output | 1 | Local request lacks permission |
| cpu_stall | output | 1 | Local request held off |
| grant_valid | input | 1 | Tokens arrive this cycle |
| grant_count | input | CW | Number of arriving tokens |
| grant_owner | input | 1 | Owner flag arrives with the tokens |
| ext_valid | input | 1 | External token request |
| ext_write | input | 1 | External request wants write permission |
| ext_persist | input | 1 | External request is persistent |
| ext_stall | output | 1 | External request not accepted this cycle |
| tok_out_valid | output | 1 | Tokens leave this cycle |
| tok_out_count | output | CW | Number of leaving tokens |
| tok_out_owner | output | 1 | Owner flag leaves with the tokens |
| req_valid | output | 1 | Token request issued |
| req_write | output | 1 | Issued request is for a store |
| req_persist | output | 1 | Issued request is an escalation |
| line_state | output | 3 | Current derived state code |
| line_tokens | output | CW | Tokens currently held |

## Verification
The hardest situations to reach are the ones that need long stretches of silence or exact timing. One is escalation after `RETRY_LIMIT` grant-free cycles. Another is the exact cycle at which the window expires. A third is a store in M, which upgrades locally and issues no request. The stimulus reaches these by walking a vector table that builds up tokens in steps. It then parks a load miss and counts idle cycles up to the escalation pulse. Finally it grants the full token count and counts down the window before issuing stores and a persistent takeover.

// File: rtl/tok_line_pkg.sv
package tok_line_pkg;

    typedef enum logic [2:0] {
        LS_I   = 3'd0,
        LS_S   = 3'd1,
        LS_O   = 3'd2,
        LS_M   = 3'd3,
        LS_MW  = 3'd4,
        LS_MM  = 3'd5,
        LS_MMW = 3'd6
    } line_state_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_REPL  = 2'd2
    } cpu_op_e;

    // Book-keeping of one outstanding miss
    typedef struct packed {
        logic active;
        logic write;
        logic persist;
    } miss_state_t;

    // State is a pure function of holdings and the lock-in window
    function automatic line_state_e derive_state(
        input logic none, input logic full, input logic owner,
        input logic dirty, input logic win);
        line_state_e s;
        if (none)      s = LS_I;
        else if (full) s = win ? (dirty ? LS_MMW : LS_MW) : (dirty ? LS_MM : LS_M);
        else           s = owner ? LS_O : LS_S;
        return s;
    endfunction

endpackage

// File: rtl/tok_window_timer.sv
module tok_window_timer #(
    parameter int WIN_CYCLES = 16,
    localparam int WW = $clog2(WIN_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic clear,
    output logic active
);
    logic [WW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (clear)         remain <= '0;
        else if (load)          remain <= WW'(WIN_CYCLES);
        else if (remain != '0)  remain <= remain - 1'b1;
    end

    assign active = (remain != '0);
endmodule

// File: rtl/tok_miss_tracker.sv
module tok_miss_tracker
    import tok_line_pkg::*;
#(
    parameter int RETRY_LIMIT = 32,
    localparam int RW = $clog2(RETRY_LIMIT + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        want_rd,
    input  logic        want_wr,
    input  logic        need_net,
    input  logic        sat_rd,
    input  logic        sat_wr,
    input  logic        grant_seen,
    output logic        done,
    output logic        req_valid,
    output logic        req_write,
    output logic        req_persist,
    output miss_state_t pend
);
    logic [RW-1:0] quiet;
    logic open_rd, open_wr, opening, issue, esc;

    assign open_rd = want_rd && !pend.active;
    assign open_wr = want_wr && !(pend.active && pend.write);
    assign opening = open_rd || open_wr;
    assign issue   = opening && need_net;
    assign esc     = pend.active && !pend.persist && (quiet == RW'(RETRY_LIMIT));
    assign done    = pend.active && (pend.write ? sat_wr : sat_rd);

    assign req_valid   = issue || esc;
    assign req_write   = issue ? want_wr : pend.write;
    assign req_persist = esc && !issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= '0;
            quiet <= '0;
        end else if (opening) begin
            pend.active  <= 1'b1;
            pend.write   <= pend.write || want_wr;
            pend.persist <= 1'b0;
            quiet        <= '0;
        end else if (done) begin
            pend  <= '0;
            quiet <= '0;
        end else if (pend.active && !pend.persist) begin
            if (esc)             pend.persist <= 1'b1;
            if (grant_seen)      quiet <= '0;
            else if (!esc)       quiet <= quiet + 1'b1;
        end
    end
endmodule

// File: rtl/tok_line_ctrl.sv
module tok_line_ctrl
    import tok_line_pkg::*;
#(
    parameter int TOKENS      = 4,
    parameter int WIN_CYCLES  = 16,
    parameter int RETRY_LIMIT = 32,
    localparam int CW = $clog2(TOKENS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    output logic          cpu_hit,
    output logic          cpu_miss,
    output logic          cpu_stall,
    input  logic          grant_valid,
    input  logic [CW-1:0] grant_count,
    input  logic          grant_owner,
    input  logic          ext_valid,
    input  logic          ext_write,
    input  logic          ext_persist,
    output logic          ext_stall,
    output logic          tok_out_valid,
    output logic [CW-1:0] tok_out_count,
    output logic          tok_out_owner,
    output logic          req_valid,
    output logic          req_write,
    output logic          req_persist,
    output logic [2:0]    line_state,
    output logic [CW-1:0] line_tokens
);
    localparam logic [CW-1:0] ALL = CW'(TOKENS);

    logic [CW-1:0] tok, tok_next, out_cnt, in_cnt;
    logic          owner, dirty, win;
    logic          none, full, full_next;
    logic          is_ld, is_st, is_rp;
    logic          pers_take, serve, store_ok, ext_take, keep_one, send;
    logic          done, win_load;
    line_state_e   st;
    miss_state_t   pend;

    assign none  = (tok == '0);
    assign full  = (tok == ALL);
    assign is_ld = (cpu_op == OP_LOAD);
    assign is_st = (cpu_op == OP_STORE);
    assign is_rp = (cpu_op == OP_REPL);
    assign st    = derive_state(none, full, owner, dirty, win);

    // Local side: persistent takeover and window both hold the CPU off
    assign pers_take = ext_valid && ext_persist;
    assign cpu_stall = cpu_valid && (pers_take || (is_rp && win));
    assign serve     = cpu_valid && !cpu_stall;
    assign store_ok  = full && (win || dirty);
    assign cpu_hit   = serve && ((is_ld && !none) || (is_st && store_ok) || is_rp);
    assign cpu_miss  = serve && ((is_ld && none) || (is_st && !store_ok));

    // External side: ordinary requests yield to the window and to the CPU
    assign ext_stall = ext_valid && !ext_persist && (win || cpu_valid);
    assign ext_take  = ext_valid && !ext_stall;
    assign keep_one  = ext_take && !ext_write && !ext_persist && !full && (tok > CW'(1));
    assign send      = ext_take || (serve && is_rp);

    assign out_cnt       = send ? (keep_one ? tok - CW'(1) : tok) : '0;
    assign tok_out_valid = send && !none;
    assign tok_out_count = out_cnt;
    assign tok_out_owner = tok_out_valid && owner;

    assign in_cnt    = grant_valid ? grant_count : '0;
    assign tok_next  = tok - out_cnt + in_cnt;
    assign full_next = (tok_next == ALL);
    assign win_load  = done && full_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            tok   <= '0;
            owner <= 1'b0;
            dirty <= 1'b0;
        end else begin
            tok   <= tok_next;
            owner <= ((owner && !tok_out_valid) || (grant_valid && grant_owner))
                     && (tok_next != '0);
            if (tok_out_valid || !full_next) dirty <= 1'b0;
            else if (cpu_hit && is_st)       dirty <= 1'b1;
        end
    end

    tok_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk    (clk),
        .rst    (rst),
        .load   (win_load),
        .clear  (send),
        .active (win)
    );

    tok_miss_tracker #(.RETRY_LIMIT(RETRY_LIMIT)) u_miss (
        .clk         (clk),
        .rst         (rst),
        .want_rd     (cpu_miss && is_ld),
        .want_wr     (cpu_miss && is_st),
        .need_net    (is_ld ? none : !full),
        .sat_rd      (tok_next != '0),
        .sat_wr      (full_next),
        .grant_seen  (grant_valid),
        .done        (done),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_persist (req_persist),
        .pend        (pend)
    );

    assign line_state  = st;
    assign line_tokens = tok;
endmodule

// File: rtl/tok_line_chk.sv
module tok_line_chk
    import tok_line_pkg::*;
#(
    parameter int TOKENS = 4,
    localparam int CW = $clog2(TOKENS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          cpu_valid,
    input logic [1:0]    cpu_op,
    input logic          cpu_hit,
    input logic          cpu_miss,
    input logic          cpu_stall,
    input logic          grant_valid,
    input logic [CW-1:0] grant_count,
    input logic          ext_valid,
    input logic          ext_persist,
    input logic          ext_stall,
    input logic          tok_out_valid,
    input logic [CW-1:0] tok_out_count,
    input logic          req_valid,
    input logic [2:0]    line_state,
    input logic [CW-1:0] line_tokens
);
    logic win_state;
    assign win_state = (line_state == 3'(LS_MW)) || (line_state == 3'(LS_MMW));

    AST_TOKEN_CAP: assert property (@(posedge clk) disable iff (rst)
        line_tokens <= CW'(TOKENS)); // R1
    AST_TOKEN_FLOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> line_tokens == $past(line_tokens)
                 - ($past(tok_out_valid) ? $past(tok_out_count) : CW'(0))
                 + ($past(grant_valid) ? $past(grant_count) : CW'(0))); // R1
    AST_STORE_ALL_TOKENS: assert property (@(posedge clk) disable iff (rst)
        (cpu_hit && cpu_op == 2'(OP_STORE)) |-> line_tokens == CW'(TOKENS)); // R2
    AST_LOAD_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (rst)
        (cpu_hit && cpu_op == 2'(OP_LOAD)) |-> line_tokens != '0); // R2
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_hit, cpu_miss, cpu_stall})); // R2
    AST_SILENT_UPGRADE: assert property (@(posedge clk) disable iff (rst)
        (line_state == 3'(LS_MW) && cpu_hit && cpu_op == 2'(OP_STORE))
        |-> !req_valid ##1 line_state == 3'(LS_MMW)); // R4
    AST_WINDOW_HOLDS_REPL: assert property (@(posedge clk) disable iff (rst)
        (win_state && cpu_valid && cpu_op == 2'(OP_REPL)) |-> (cpu_stall && !cpu_hit)); // R5
    AST_WINDOW_HOLDS_EXT: assert property (@(posedge clk) disable iff (rst)
        (win_state && ext_valid && !ext_persist) |-> ext_stall); // R5
    AST_PERSIST_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (ext_valid && ext_persist) |-> (!ext_stall && tok_out_count == line_tokens)); // R8
endmodule

bind tok_line_ctrl tok_line_chk #(.TOKENS(TOKENS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_valid     (cpu_valid),
    .cpu_op        (cpu_op),
    .cpu_hit       (cpu_hit),
    .cpu_miss      (cpu_miss),
    .cpu_stall     (cpu_stall),
    .grant_valid   (grant_valid),
    .grant_count   (grant_count),
    .ext_valid     (ext_valid),
    .ext_persist   (ext_persist),
    .ext_stall     (ext_stall),
    .tok_out_valid (tok_out_valid),
    .tok_out_count (tok_out_count),
    .req_valid     (req_valid),
    .line_state    (line_state),
    .line_tokens   (line_tokens)
);

// File: tb/sim_tok_line_ctrl.sv
module sim_tok_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NT    = 4;
    localparam int WIN   = 16;
    localparam int RETRY = 32;

    typedef struct packed {
        logic       cv;  logic [1:0] op;
        logic       gv;  logic [2:0] gt; logic go;
        logic       ev;  logic ew;  logic ep;
        logic       hit; logic miss; logic cst; logic est; logic req;
        logic [2:0] oc;  logic [2:0] st; logic [2:0] tk;
    } vec_t;

    // cv op gv gt go ev ew ep | hit miss cst est req oc st tk
    localparam vec_t TAB [16] = '{
        '{1'b1,2'd0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,3'd0,3'd0,3'd0}, // R2 R9 load miss in I
        '{1'b0,2'd0,1'b1,3'd2,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd2}, // R1 grant two -> S
        '{1'b1,2'd0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd2}, // R2 load hit in S
        '{1'b1,2'd1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,3'd0,3'd1,3'd2}, // R3 R9 store miss in S
        '{1'b0,2'd0,1'b1,3'd2,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd4,3'd4}, // R6 full -> M_W
        '{1'b1,2'd2,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b1,1'b0,1'b0,3'd0,3'd4,3'd4}, // R5 replace held
        '{1'b0,2'd0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b1,1'b0,3'd0,3'd4,3'd4}, // R5 ext held
        '{1'b1,2'd1,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd6,3'd4}, // R4 silent upgrade
        '{1'b1,2'd0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,3'd0,3'd6,3'd4}, // R2 load in MM_W
        '{1'b0,2'd0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,3'd0,3'd0}, // R7 ext read in MM -> I
        '{1'b1,2'd0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b1,3'd0,3'd0,3'd0}, // R9 load miss
        '{1'b0,2'd0,1'b1,3'd3,1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd2,3'd3}, // R1 three with owner -> O
        '{1'b0,2'd0,1'b0,3'd0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,3'd1,3'd1}, // R7 read in O keeps one
        '{1'b0,2'd0,1'b1,3'd2,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd3}, // R1 grant two -> S
        '{1'b1,2'd2,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,3'd0,3'd0}, // R11 replace drains
        '{1'b1,2'd0,1'b0,3'd0,1'b0,1'b1,1'b1,1'b0, 1'b0,1'b1,1'b0,1'b1,1'b1,3'd0,3'd0,3'd0}  // R7 R9 ext yields to CPU
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_valid, cpu_hit, cpu_miss, cpu_stall;
    logic [1:0] cpu_op;
    logic       grant_valid, grant_owner;
    logic [2:0] grant_count;
    logic       ext_valid, ext_write, ext_persist, ext_stall;
    logic       tok_out_valid, tok_out_owner;
    logic [2:0] tok_out_count;
    logic       req_valid, req_write, req_persist;
    logic [2:0] line_state;
    logic [2:0] line_tokens;

    int checks = 0;
    int errors = 0;
    int pool   = NT;
    logic s_rp;

    always #(CLK_PERIOD/2) clk = ~clk;

    tok_line_ctrl #(.TOKENS(NT), .WIN_CYCLES(WIN), .RETRY_LIMIT(RETRY)) u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op),
        .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .cpu_stall(cpu_stall),
        .grant_valid(grant_valid), .grant_count(grant_count), .grant_owner(grant_owner),
        .ext_valid(ext_valid), .ext_write(ext_write), .ext_persist(ext_persist),
        .ext_stall(ext_stall),
        .tok_out_valid(tok_out_valid), .tok_out_count(tok_out_count),
        .tok_out_owner(tok_out_owner),
        .req_valid(req_valid), .req_write(req_write), .req_persist(req_persist),
        .line_state(line_state), .line_tokens(line_tokens)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    function automatic vec_t idle(input logic [2:0] st, input logic [2:0] tk);
        vec_t v = '0;
        v.st = st;
        v.tk = tk;
        return v;
    endfunction

    task automatic step(input vec_t v);
        @(negedge clk);
        cpu_valid = v.cv;  cpu_op = v.op;
        grant_valid = v.gv; grant_count = v.gt; grant_owner = v.go;
        ext_valid = v.ev;  ext_write = v.ew; ext_persist = v.ep;
        #1;
        chk("R2", "cpu_hit", cpu_hit, v.hit);
        chk("R2", "cpu_miss", cpu_miss, v.miss);
        chk("R5", "cpu_stall", cpu_stall, v.cst);
        chk("R5", "ext_stall", ext_stall, v.est);
        chk("R9", "req_valid", req_valid, v.req);
        chk("R7", "tok_out", tok_out_valid ? int'(tok_out_count) : 0, v.oc);
        s_rp = req_persist;
        pool = pool - (grant_valid ? int'(grant_count) : 0)
                    + (tok_out_valid ? int'(tok_out_count) : 0);
        @(posedge clk);
        #1;
        chk("R6", "line_state", line_state, v.st);
        chk("R1", "line_tokens", line_tokens, v.tk);
        chk("R1", "conservation", pool + int'(line_tokens), NT);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        vec_t v;
        rst = 1'b1;
        cpu_valid = 0; cpu_op = 0; grant_valid = 0; grant_count = 0; grant_owner = 0;
        ext_valid = 0; ext_write = 0; ext_persist = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R12", "reset state", line_state, 0);
        chk("R12", "reset tokens", line_tokens, 0);
        chk("R12", "reset tok_out", tok_out_valid, 0);
        chk("R12", "reset req", req_valid, 0);

        for (int i = 0; i < 16; i++) begin
            if (i == 9) begin
                // R6: window opened at vector 4; four edges used, twelve remain
                for (int j = 0; j < 11; j++) step(idle(3'd6, 3'd4));
                step(idle(3'd5, 3'd4)); // R6 MM_W falls back to MM
            end
            step(TAB[i]);
        end

        // R10: load miss parked by the last vector, no grants follow
        for (int j = 0; j < RETRY; j++) step(idle(3'd0, 3'd0));
        v = idle(3'd0, 3'd0);
        v.req = 1'b1;
        step(v);
        chk("R10", "req_persist", s_rp, 1);
        step(idle(3'd0, 3'd0)); // R10 single escalation pulse

        // R6: full grant on a pending load opens M_W, then expiry to M
        v = idle(3'd4, 3'd4);
        v.gv = 1'b1; v.gt = 3'd4; v.go = 1'b1;
        step(v);
        for (int j = 0; j < WIN - 1; j++) step(idle(3'd4, 3'd4));
        step(idle(3'd3, 3'd4)); // R6 M_W falls back to M

        // R3: store in M misses without a request, then M_W, then hit
        v = idle(3'd3, 3'd4);
        v.cv = 1'b1; v.op = 2'd1; v.miss = 1'b1;
        step(v);
        v.st = 3'd4;
        step(v);
        v = idle(3'd6, 3'd4);
        v.cv = 1'b1; v.op = 2'd1; v.hit = 1'b1;
        step(v); // R3 R4 store hits in M_W, line becomes MM_W

        // R5: ordinary external write held inside the window
        v = idle(3'd6, 3'd4);
        v.ev = 1'b1; v.ew = 1'b1; v.est = 1'b1;
        step(v);

        // R8: persistent request wins over window and CPU load
        v = idle(3'd0, 3'd0);
        v.cv = 1'b1; v.op = 2'd0; v.cst = 1'b1;
        v.ev = 1'b1; v.ep = 1'b1; v.oc = 3'd4;
        step(v);

        // R8 R11: window closed, replacement in I no longer held
        v = idle(3'd0, 3'd0);
        v.cv = 1'b1; v.op = 2'd2; v.hit = 1'b1;
        step(v);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule